// File: doc/BRIEF.md
# Arbitrating I2C Bit Engine

A bit-level master for a shared two-wire I2C bus on which other masters may also be active. A higher-level byte controller hands it one operation at a time: START, STOP, WRITE of one bit, or READ of one bit. The engine builds the serial clock from the system clock. It drives both lines open-drain through pull-enable outputs and reports each completed operation with a one-cycle strobe.

The engine does not assume the bus follows its own outputs. It watches the real line levels through a synchronizer. Any clock-high phase waits while another device holds the clock low. A WRITE of 1 that reads back a low data line is treated as lost arbitration, and both lines are freed at once. The engine also tracks whether the bus is busy by watching START and STOP conditions from any master. It refuses a START while another transaction is open, and it gives up with a timeout if the clock is held low too long.

Each bit takes four quarter phases of `SYS_HZ / (4 * BUS_HZ)` cycles. With the defaults of 50 MHz and 100 kHz, that is 125 cycles per quarter.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, `clk_pull_o` and `data_pull_o` are 0 (both lines released), `cmd_ready_o` is 1 and `done_o` is 0.
- R2: `cmd_i` encodes 0 = START, 1 = STOP, 2 = WRITE, 3 = READ. A command is taken when `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_ready_o` stays 0 while the operation runs. Completion is a `done_o` pulse exactly one cycle long.
- R3: START releases both lines, pulls the data line low while the clock line is high, then pulls the clock line low. It ends with both pulls at 1.
- R4: STOP pulls data low under a low clock, releases the clock, then releases data while the clock is high. It ends with both pulls at 0.
- R5: WRITE presents `wbit_i` on the data line (1 = released, 0 = pulled) across the whole clock-high phase. The data line changes only while the clock line is pulled low, so no START or STOP appears on the bus.
- R6: READ releases the data line. At `done_o`, `rbit_o` equals the data level sampled in the middle of the clock-high phase.
- R7: Each quarter lasts `SYS_HZ/(4*BUS_HZ)` cycles. A quarter in which the clock is released starts counting only once the synchronized clock line (`SYNC_STAGES` flops) reads high. Each clock-high phase therefore lasts at least two quarters.
- R8: While another device holds the clock line low, the engine waits without completing. When the hold lasts fewer than `STRETCH_LIMIT` cycles, the operation completes normally with `timeout_o` = 0.
- R9: If the clock line stays low for `STRETCH_LIMIT` cycles in a released-clock quarter, the operation aborts. `done_o` pulses with `timeout_o` = 1 and both pulls become 0.
- R10: A WRITE of 1 that samples the data line low at mid-high aborts with `arb_lost_o` = 1 and releases both lines. A WRITE of 0 never reports lost arbitration.
- R11: The bus counts as busy from a START seen on the lines until a STOP seen on the lines. A START command while busy gets `done_o` on the next cycle with `start_err_o` = 1, and neither pull changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine can take a command |
| cmd_i | input | 2 | Operation code |
| wbit_i | input | 1 | Bit to write |
| done_o | output | 1 | One-cycle completion strobe |
| rbit_o | output | 1 | Sampled data bit |
| arb_lost_o | output | 1 | Last operation lost arbitration |
| start_err_o | output | 1 | Last START refused, bus busy |
| timeout_o | output | 1 | Last operation aborted on a held clock |
| clk_line_i | input | 1 | Level of the bus clock line |
| data_line_i | input | 1 | Level of the bus data line |
| clk_pull_o | output | 1 | 1 pulls the clock line low |
| data_pull_o | output | 1 | 1 pulls the data line low |

## Verification
The data sample and the arbitration check fall on the same mid-high edge. A WRITE of 1 therefore has to decide, in one cycle, between recording the readback and aborting. The bench provokes this by holding the data line low from the bench side during a WRITE of 1. It judges that the strobe carries `arb_lost_o` = 1 with both pulls released. Under the same external pull, a WRITE of 0 must finish with the flag clear.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  // {clock level, data level} per quarter; 1 = released
  function automatic logic [1:0] quarter_levels(op_e op, logic [1:0] q, logic b);
    logic [1:0] lv;
    case (op)
      OP_START: lv = (q == 2'd3) ? 2'b00 : (q == 2'd2) ? 2'b10 : 2'b11;
      OP_STOP:  lv = (q == 2'd0) ? 2'b00 : (q == 2'd3) ? 2'b11 : 2'b10;
      default:  lv = {(q == 2'd1) || (q == 2'd2), (op == OP_READ) ? 1'b1 : b};
    endcase
    return lv;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg <= '1;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ck_i,
  input  logic sd_i,
  output logic busy_o
);
  logic ck_q, sd_q;
  logic start_seen, stop_seen;

  assign start_seen = ck_q && ck_i && sd_q && !sd_i;
  assign stop_seen  = ck_q && ck_i && !sd_q && sd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q   <= 1'b1;
      sd_q   <= 1'b1;
      busy_o <= 1'b0;
    end else begin
      ck_q <= ck_i;
      sd_q <= sd_i;
      if (start_seen)     busy_o <= 1'b1;
      else if (stop_seen) busy_o <= 1'b0;
    end
  end

  assert_busy_on_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(ck_i) && !$past(sd_i));
  assert_idle_on_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(ck_i) && $past(sd_i));
endmodule

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer #(
  parameter int CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  logic [CW-1:0] cnt;

  assign last_o = run_i && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= '0;
    else if (clear_i || last_o) cnt <= '0;
    else if (run_i)             cnt <= cnt + 1'b1;
  end

  // stretch freezes the quarter count
  assert_frozen_while_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !clear_i |=> $stable(cnt));
endmodule

// File: rtl/i2c_stretch_guard.sv
module i2c_stretch_guard #(
  parameter int LIMIT = 100_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  output logic expired_o
);
  localparam int LW = $clog2(LIMIT + 1);
  logic [LW-1:0] cnt;

  assign expired_o = wait_i && (cnt == LW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt <= '0;
    else if (!wait_i)    cnt <= '0;
    else if (!expired_o) cnt <= cnt + 1'b1;
  end

  assert_wait_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= LW'(LIMIT - 1));
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int SYS_HZ        = 50_000_000,
  parameter int BUS_HZ        = 100_000,
  parameter int STRETCH_LIMIT = 100_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [1:0] cmd_i,
  input  logic       wbit_i,
  output logic       done_o,
  output logic       rbit_o,
  output logic       arb_lost_o,
  output logic       start_err_o,
  output logic       timeout_o,
  input  logic       clk_line_i,
  input  logic       data_line_i,
  output logic       clk_pull_o,
  output logic       data_pull_o
);
  localparam int QUARTER_CYC = SYS_HZ / (4 * BUS_HZ);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e        st;
  op_e        op_q;
  logic       bit_q;
  logic [1:0] qtr;
  logic       hold_ck, hold_sd;
  logic [1:0] lines_s, lvl;
  logic       ck_s, sd_s, bus_busy;
  logic       running, accept, refuse, wait_high, q_last, expired, mid, arb_hit;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({clk_line_i, data_line_i}), .q_o(lines_s)
  );
  assign ck_s = lines_s[1];
  assign sd_s = lines_s[0];

  i2c_bus_watch u_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .ck_i(ck_s), .sd_i(sd_s), .busy_o(bus_busy)
  );

  assign running     = (st == ST_RUN);
  assign lvl         = quarter_levels(op_q, qtr, bit_q);
  assign clk_pull_o  = running ? !lvl[1] : !hold_ck;
  assign data_pull_o = running ? !lvl[0] : !hold_sd;

  assign cmd_ready_o = !running && !done_o;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign refuse      = accept && (op_e'(cmd_i) == OP_START) && bus_busy;
  assign wait_high   = running && lvl[1] && !ck_s;

  i2c_quarter_timer #(.CYC(QUARTER_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept),
    .run_i(running && !wait_high), .last_o(q_last)
  );

  i2c_stretch_guard #(.LIMIT(STRETCH_LIMIT)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .wait_i(wait_high), .expired_o(expired)
  );

  // end of quarter 1 = middle of the clock-high phase
  assign mid     = q_last && (qtr == 2'd1);
  assign arb_hit = mid && (op_q == OP_WRITE) && bit_q && !sd_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      op_q        <= OP_START;
      bit_q       <= 1'b0;
      qtr         <= 2'd0;
      hold_ck     <= 1'b1;
      hold_sd     <= 1'b1;
      done_o      <= 1'b0;
      rbit_o      <= 1'b0;
      arb_lost_o  <= 1'b0;
      start_err_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!running) begin
        if (accept) begin
          arb_lost_o  <= 1'b0;
          timeout_o   <= 1'b0;
          start_err_o <= refuse;
          if (refuse) begin
            done_o <= 1'b1;
          end else begin
            st    <= ST_RUN;
            op_q  <= op_e'(cmd_i);
            bit_q <= wbit_i;
            qtr   <= 2'd0;
          end
        end
      end else if (expired) begin
        st        <= ST_IDLE;
        hold_ck   <= 1'b1;
        hold_sd   <= 1'b1;
        done_o    <= 1'b1;
        timeout_o <= 1'b1;
      end else if (arb_hit) begin
        st         <= ST_IDLE;
        hold_ck    <= 1'b1;
        hold_sd    <= 1'b1;
        done_o     <= 1'b1;
        arb_lost_o <= 1'b1;
      end else if (q_last) begin
        if (mid) rbit_o <= sd_s;
        if (qtr == 2'd3) begin
          st      <= ST_IDLE;
          hold_ck <= lvl[1];
          hold_sd <= lvl[0];
          done_o  <= 1'b1;
        end else begin
          qtr <= qtr + 2'd1;
        end
      end
    end
  end

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_after_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !refuse |=> !cmd_ready_o);
  assert_data_moves_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(data_pull_o) && !clk_pull_o && !$past(clk_pull_o)
      |-> (running && (op_q == OP_START || op_q == OP_STOP)) || timeout_o);
  assert_hold_while_stretched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_high && !expired |=> $stable(qtr) && running);
  assert_abort_frees_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (arb_lost_o || timeout_o) |-> !clk_pull_o && !data_pull_o);
  assert_refuse_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_err_o |-> $stable(clk_pull_o) && $stable(data_pull_o));
endmodule

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;
  localparam int Q     = 4;
  localparam int LIMIT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic wbit = 1'b0;
  logic tb_ck_hold = 1'b0;
  logic tb_dat_pull = 1'b0;
  logic cmd_ready, done, rbit, arb_lost, start_err, timeout, clk_pull, data_pull;
  logic clk_line, data_line;

  int checks = 0;
  int errors = 0;
  int wd = 0;
  int start_evt = 0, stop_evt = 0, rises = 0, hi_run = 0, last_hi = 0;
  logic prev_ck = 1'b1, prev_sd = 1'b1;
  logic [7:0] seen_bits = 8'h00;
  logic rdy_after;

  always #2 clk = ~clk;

  assign clk_line  = !(clk_pull | tb_ck_hold);
  assign data_line = !(data_pull | tb_dat_pull);

  i2c_bit_engine #(.SYS_HZ(1_600_000), .BUS_HZ(100_000), .STRETCH_LIMIT(LIMIT), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_i(cmd), .wbit_i(wbit), .done_o(done), .rbit_o(rbit), .arb_lost_o(arb_lost),
    .start_err_o(start_err), .timeout_o(timeout), .clk_line_i(clk_line),
    .data_line_i(data_line), .clk_pull_o(clk_pull), .data_pull_o(data_pull)
  );

  // bus observer
  always @(posedge clk) begin
    if (prev_ck && clk_line && prev_sd && !data_line) start_evt++;
    if (prev_ck && clk_line && !prev_sd && data_line) stop_evt++;
    if (!prev_ck && clk_line) begin
      rises++;
      seen_bits = {seen_bits[6:0], data_line};
    end
    if (clk_line) hi_run++;
    else if (hi_run > 0) begin
      last_hi = hi_run;
      hi_run = 0;
    end
    prev_ck = clk_line;
    prev_sd = data_line;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic b, output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd = c;
    wbit = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    rdy_after = cmd_ready;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R2 completion strobe", int'(done), 1);
  endtask

  task automatic t_reset;
    chk(!clk_pull && !data_pull, "R1 lines released", int'({clk_pull, data_pull}), 0);
    chk(cmd_ready && !done, "R1 ready idle", int'({cmd_ready, done}), 2);
  endtask

  task automatic t_start;
    int cyc, s0;
    s0 = start_evt;
    run_cmd(2'd0, 1'b0, cyc);
    chk(!rdy_after, "R2 ready low while running", int'(rdy_after), 0);
    chk(!start_err, "R3 start accepted", int'(start_err), 0);
    chk(start_evt == s0 + 1, "R3 start condition seen", start_evt - s0, 1);
    chk(clk_pull && data_pull, "R3 both pulled after start", int'({clk_pull, data_pull}), 3);
    @(negedge clk);
    chk(!done, "R2 strobe one cycle", int'(done), 0);
  endtask

  task automatic t_write(input logic [7:0] v);
    int cyc, r0, s0, p0;
    r0 = rises; s0 = start_evt; p0 = stop_evt;
    for (int i = 7; i >= 0; i--) begin
      run_cmd(2'd2, v[i], cyc);
      chk(!arb_lost, "R5 no arbitration loss", int'(arb_lost), 0);
    end
    chk(rises - r0 == 8, "R5 eight clock pulses", rises - r0, 8);
    chk(seen_bits == v, "R5 bits on bus", int'(seen_bits), int'(v));
    chk(start_evt == s0 && stop_evt == p0, "R5 no data edge under high clock",
        start_evt + stop_evt - s0 - p0, 0);
    chk(last_hi >= 2 * Q && last_hi <= 2 * Q + 3, "R7 high phase length", last_hi, 2 * Q + 2);
  endtask

  task automatic t_read;
    int cyc;
    tb_dat_pull = 1'b1;
    run_cmd(2'd3, 1'b0, cyc);
    chk(rbit == 1'b0, "R6 read low", int'(rbit), 0);
    tb_dat_pull = 1'b0;
    run_cmd(2'd3, 1'b0, cyc);
    chk(rbit == 1'b1, "R6 read high", int'(rbit), 1);
    chk(!data_pull, "R6 data released", int'(data_pull), 0);
  endtask

  task automatic t_stretch;
    int cyc;
    bit early;
    early = 1'b0;
    tb_ck_hold = 1'b1;
    fork
      run_cmd(2'd2, 1'b1, cyc);
      begin
        repeat (24) begin
          @(negedge clk);
          if (done || clk_line) early = 1'b1;
        end
        tb_ck_hold = 1'b0;
      end
    join
    chk(!early, "R8 waits while clock held", int'(early), 0);
    chk(!timeout && !arb_lost, "R8 no timeout on short stretch", int'(timeout), 0);
    chk(cyc >= 24 + 2 * Q, "R8 finished after release", cyc, 24 + 2 * Q);
    chk(last_hi >= 2 * Q, "R7 full high after stretch", last_hi, 2 * Q + 2);
  endtask

  task automatic t_stop;
    int cyc, p0;
    p0 = stop_evt;
    run_cmd(2'd1, 1'b0, cyc);
    chk(stop_evt == p0 + 1, "R4 stop condition seen", stop_evt - p0, 1);
    chk(!clk_pull && !data_pull, "R4 released after stop", int'({clk_pull, data_pull}), 0);
  endtask

  task automatic t_arb;
    int cyc;
    run_cmd(2'd0, 1'b0, cyc);
    tb_dat_pull = 1'b1;
    run_cmd(2'd2, 1'b0, cyc);
    chk(!arb_lost, "R10 write 0 keeps arbitration", int'(arb_lost), 0);
    run_cmd(2'd2, 1'b1, cyc);
    chk(arb_lost, "R10 arbitration lost", int'(arb_lost), 1);
    chk(!clk_pull && !data_pull, "R10 lines freed", int'({clk_pull, data_pull}), 0);
  endtask

  task automatic t_refuse;
    int cyc, p0;
    run_cmd(2'd0, 1'b0, cyc);
    chk(start_err && cyc == 1, "R11 start refused while busy", int'(start_err), 1);
    chk(!clk_pull && !data_pull, "R11 lines untouched", int'({clk_pull, data_pull}), 0);
    p0 = stop_evt;
    tb_dat_pull = 1'b0;
    repeat (6) @(negedge clk);
    chk(stop_evt == p0 + 1, "R11 external stop", stop_evt - p0, 1);
    run_cmd(2'd0, 1'b0, cyc);
    chk(!start_err, "R11 start accepted after stop", int'(start_err), 0);
    run_cmd(2'd1, 1'b0, cyc);
  endtask

  task automatic t_timeout;
    int cyc;
    tb_ck_hold = 1'b1;
    run_cmd(2'd2, 1'b1, cyc);
    chk(timeout, "R9 timeout reported", int'(timeout), 1);
    chk(cyc >= LIMIT && cyc <= LIMIT + 3 * Q, "R9 timeout delay", cyc, LIMIT + Q);
    chk(!clk_pull && !data_pull, "R9 lines freed", int'({clk_pull, data_pull}), 0);
    tb_ck_hold = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100_000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_write(8'hA5);
    t_read();
    t_stretch();
    t_stop();
    t_arb();
    t_refuse();
    t_timeout();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule